// File: doc/BRIEF.md
# Serial Converter Command and Result Port

This block is the digital front end of a multi-channel serial data converter, seen from the device side. A host talks to it over a four-wire full-duplex synchronous port: an active-low select, a serial clock, a command input and a result output. In every select frame the host shifts in an 8-bit command that sets up the next conversion. In the same frame the block shifts out the result of the conversion that the previous frame asked for. The exchange is therefore pipelined by one frame.

The analog path is outside the block. A conversion core is reached through a start pulse, a busy flag and a done pulse that carries a 12-bit code. The block decodes the command into a 4-bit multiplexer address, a unipolar/bipolar flag, a bit order and an output word length. The address and the coding flag go to the core. The block keeps the order and the length so that the result can be formatted when it is sent back. The pins are synchronised into the system clock, and all state is updated in that one domain.

Top module: `adc_serial_port`

## Requirements
- R1: After reset `dout_oe` and `conv_start` are low. The first frame after reset shifts out all zeros, whatever command it carries.
- R2: The command is taken from `din` on the first eight rising `sclk` edges after `cs_n` falls, most significant bit first. Command bits [7:4] are the multiplexer address (bit 7 single/differential, bit 6 odd/sign, bits 5:4 select). Bit 3 is unipolar, bit 2 is MSB-first, and bits 1:0 are the word length. `din` activity after the eighth edge of a frame has no effect on the command.
- R3: When `cs_n` rises after a complete 8-bit command, `conv_start` pulses for exactly one clock. `conv_addr` and `conv_unipolar` carry the command's fields at that time.
- R4: A frame that ends with fewer than eight rising `sclk` edges starts no conversion. It also leaves the stored result and its format unchanged.
- R5: A complete command whose frame ends while `conv_busy` is high is dropped, and no start pulse is issued.
- R6: The result register and its format are updated only on `conv_done`. Frame N returns the result of the command accepted before frame N, formatted by that command's order and length fields.
- R7: The first result bit is on `dout` before the first rising `sclk` edge. Each later bit appears after a falling edge. With 12-bit MSB-first format, B11 down to B0 follow, and then zeros.
- R8: Word length code 01 sends 8 bits (B11..B4). Code 11 sends 16 bits (B11..B0 followed by four zeros). Codes 00 and 10 send 12 bits. Bits past the length read as zero.
- R9: With MSB-first clear, the same length-limited word is sent in reverse order. A 16-bit LSB-first word therefore starts with its four padding zeros.
- R10: `dout_oe` is high exactly while the synchronised select is low. `dout` is low whenever `dout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Frame select from the host, active low |
| sclk | input | 1 | Serial shift clock from the host |
| din | input | 1 | Serial command input |
| dout | output | 1 | Serial result output |
| dout_oe | output | 1 | Output enable for the `dout` pad driver |
| conv_start | output | 1 | One-clock request to the conversion core |
| conv_addr | output | 4 | Multiplexer address for the requested conversion |
| conv_unipolar | output | 1 | Coding for the requested conversion |
| conv_busy | input | 1 | Conversion core is working |
| conv_done | input | 1 | One-clock pulse: `conv_result` is valid |
| conv_result | input | 12 | Code from the conversion core |

## Verification
The bench walks a chain of frames in which each frame's expected output is the previous command's result, formatted by that earlier command. A design that used the current frame's order or length would send a wrong bit pattern in the very next frame. Junk is driven on `din` after the eighth bit, so a capture that keeps shifting would change the decoded address. A five-clock aborted frame and a frame that ends while the core is busy both check that no start is issued and that the next readback still shows the older result. The 8-bit and 16-bit lengths are each tried in both orders, which exposes a missing zero mask past the word length or a wrong alignment for reversed words.

// File: rtl/adcsif_pkg.sv
// Shared constants, command layout and word-length helper for the serial converter port.
package adcsif_pkg;

    localparam int CFG_BITS = 8;   // command word length
    localparam int RES_BITS = 12;  // converter code width
    localparam int WORD_MAX = 16;  // longest output word
    localparam int ADDR_BITS = 4;  // multiplexer address width

    typedef enum logic [1:0] {
        WL_12A = 2'b00,
        WL_8   = 2'b01,
        WL_12B = 2'b10,
        WL_16  = 2'b11
    } wlen_e;

    // Packed in arrival order, so a received shift register maps straight onto it.
    typedef struct packed {
        logic [ADDR_BITS-1:0] addr;
        logic                 unipolar;
        logic                 msb_first;
        wlen_e                wlen;
    } cmd_t;

    typedef struct packed {
        logic  msb_first;
        wlen_e wlen;
    } fmt_t;

    localparam int LEN_W = $clog2(WORD_MAX + 1);

    // Number of result bits sent for a word-length code.
    function automatic logic [LEN_W-1:0] word_len(input wlen_e w);
        case (w)
            WL_8:    word_len = LEN_W'(8);
            WL_16:   word_len = LEN_W'(16);
            default: word_len = LEN_W'(RES_BITS);
        endcase
    endfunction

endpackage

// File: rtl/adcsif_sync.sv
// Pin synchroniser and edge detector.
// Brings cs_n, sclk and din into the clk domain through SYNC_STAGES flops and
// flags the select and serial-clock edges. Assumes clk is several times faster than sclk.
module adcsif_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_pin,
    input  logic sclk_pin,
    input  logic din_pin,
    output logic cs_active,
    output logic cs_start,
    output logic cs_end,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic din_s
);

    logic [SYNC_STAGES:0]   cs_sh;
    logic [SYNC_STAGES:0]   sck_sh;
    logic [SYNC_STAGES-1:0] din_sh;

    // Shift the pins through the synchroniser chains (extra stage kept for edge detection).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_sh  <= '1;
            sck_sh <= '0;
            din_sh <= '0;
        end else begin
            cs_sh  <= {cs_sh[SYNC_STAGES-1:0], cs_n_pin};
            sck_sh <= {sck_sh[SYNC_STAGES-1:0], sclk_pin};
            din_sh <= {din_sh[SYNC_STAGES-2:0], din_pin};
        end
    end

    assign cs_active = ~cs_sh[SYNC_STAGES-1];
    assign cs_start  = cs_sh[SYNC_STAGES] & ~cs_sh[SYNC_STAGES-1];
    assign cs_end    = ~cs_sh[SYNC_STAGES] & cs_sh[SYNC_STAGES-1];
    assign sclk_rise = ~sck_sh[SYNC_STAGES] & sck_sh[SYNC_STAGES-1];
    assign sclk_fall = sck_sh[SYNC_STAGES] & ~sck_sh[SYNC_STAGES-1];
    assign din_s     = din_sh[SYNC_STAGES-1];

endmodule

// File: rtl/adcsif_frame.sv
// Frame engine: captures the command word and serialises the stored result.
// Takes the first CFG_BITS rising sclk edges of a frame as the command and
// reports it when the frame closes complete. Loads the formatted result at frame
// start and advances one bit per falling sclk edge that follows a rising edge.
module adcsif_frame
    import adcsif_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_active,
    input  logic                cs_start,
    input  logic                cs_end,
    input  logic                sclk_rise,
    input  logic                sclk_fall,
    input  logic                din_s,
    input  logic [RES_BITS-1:0] res,
    input  fmt_t                fmt,
    output logic                cmd_valid,
    output cmd_t                cmd,
    output logic                dout,
    output logic                dout_oe
);

    localparam int IN_W = $clog2(CFG_BITS + 1);
    localparam logic [IN_W-1:0] IN_FULL = IN_W'(CFG_BITS);

    logic [CFG_BITS-1:0] in_sr;
    logic [IN_W-1:0]     in_cnt;
    logic [WORD_MAX-1:0] out_sr;
    logic [LEN_W-1:0]    out_cnt;
    logic [LEN_W-1:0]    out_len;
    logic                rise_seen;
    logic [WORD_MAX-1:0] base_w;
    logic [WORD_MAX-1:0] rev_w;
    logic [WORD_MAX-1:0] load_w;
    logic [LEN_W-1:0]    load_len;

    // Shift in command bits on the first CFG_BITS rising edges of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sr  <= '0;
            in_cnt <= '0;
        end else if (cs_start) begin
            in_cnt <= '0;
        end else if (cs_active && sclk_rise && in_cnt != IN_FULL) begin
            in_sr  <= {in_sr[CFG_BITS-2:0], din_s};
            in_cnt <= in_cnt + 1'b1;
        end
    end

    // Report a complete command when the frame closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd       <= '0;
        end else begin
            cmd_valid <= cs_end && (in_cnt == IN_FULL);
            if (cs_end && (in_cnt == IN_FULL)) cmd <= cmd_t'(in_sr);
        end
    end

    // Build the outgoing word: left-aligned code, reversed and re-aligned for LSB-first.
    always_comb begin
        base_w   = {res, {(WORD_MAX-RES_BITS){1'b0}}};
        load_len = word_len(fmt.wlen);
        for (int k = 0; k < WORD_MAX; k++) rev_w[k] = base_w[WORD_MAX-1-k];
        load_w = fmt.msb_first ? base_w : (rev_w << (LEN_W'(WORD_MAX) - load_len));
    end

    // Load at frame start, then shift one bit per falling edge that follows a rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sr    <= '0;
            out_cnt   <= '0;
            out_len   <= '0;
            rise_seen <= 1'b0;
        end else if (cs_start) begin
            out_sr    <= load_w;
            out_cnt   <= '0;
            out_len   <= load_len;
            rise_seen <= 1'b0;
        end else if (cs_active) begin
            if (sclk_rise) rise_seen <= 1'b1;
            if (sclk_fall && rise_seen) begin
                rise_seen <= 1'b0;
                out_sr    <= {out_sr[WORD_MAX-2:0], 1'b0};
                if (out_cnt != out_len) out_cnt <= out_cnt + 1'b1;
            end
        end
    end

    assign dout    = cs_active && (out_cnt < out_len) && out_sr[WORD_MAX-1];
    assign dout_oe = cs_active;

    assert_cmd_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cnt == IN_FULL && !cs_start) |=> $stable(in_sr));

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_active |-> (out_cnt <= out_len));

    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |-> !dout);

endmodule

// File: rtl/adc_serial_port.sv
// Top of the serial converter port.
// Joins the synchroniser and frame engine, hands accepted commands to the
// conversion core and keeps the latest code with the format its command chose.
// Assumes the core raises conv_busy the clock after conv_start.
module adc_serial_port
    import adcsif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sclk,
    input  logic                 din,
    output logic                 dout,
    output logic                 dout_oe,
    output logic                 conv_start,
    output logic [ADDR_BITS-1:0] conv_addr,
    output logic                 conv_unipolar,
    input  logic                 conv_busy,
    input  logic                 conv_done,
    input  logic [RES_BITS-1:0]  conv_result
);

    localparam fmt_t FMT_RESET = '{msb_first: 1'b1, wlen: WL_12A};

    logic                cs_active, cs_start, cs_end, sclk_rise, sclk_fall, din_s;
    logic                cmd_valid;
    cmd_t                cmd;
    fmt_t                pend_fmt;
    fmt_t                res_fmt;
    logic [RES_BITS-1:0] res_q;

    adcsif_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_pin  (cs_n),
        .sclk_pin  (sclk),
        .din_pin   (din),
        .cs_active (cs_active),
        .cs_start  (cs_start),
        .cs_end    (cs_end),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din_s     (din_s)
    );

    adcsif_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active),
        .cs_start  (cs_start),
        .cs_end    (cs_end),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .din_s     (din_s),
        .res       (res_q),
        .fmt       (res_fmt),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

    // Issue a start for a complete command unless the core is still busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start    <= 1'b0;
            conv_addr     <= '0;
            conv_unipolar <= 1'b0;
            pend_fmt      <= FMT_RESET;
        end else begin
            conv_start <= cmd_valid && !conv_busy;
            if (cmd_valid && !conv_busy) begin
                conv_addr     <= cmd.addr;
                conv_unipolar <= cmd.unipolar;
                pend_fmt      <= '{msb_first: cmd.msb_first, wlen: cmd.wlen};
            end
        end
    end

    // Keep the finished code together with the format its command asked for.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            res_fmt <= FMT_RESET;
        end else if (conv_done) begin
            res_q   <= conv_result;
            res_fmt <= pend_fmt;
        end
    end

    assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_start_idle_core_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !$past(conv_busy));

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> ($stable(res_q) && $stable(res_fmt)));

endmodule

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;

    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;     // system clocks per sclk half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic        dout, dout_oe, conv_start, conv_unipolar;
    logic [3:0]  conv_addr;
    logic        conv_busy = 1'b0;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // core model state
    int          busy_len = 20;
    int          busy_cnt = 0;
    int          starts = 0;
    int          wide_starts = 0;
    logic        last_start = 1'b0;
    logic [3:0]  got_addr = '0;
    logic        got_uni = 1'b0;

    // expected pipeline state
    logic [11:0] e_res = '0;
    logic        e_msbf = 1'b1;
    logic [1:0]  e_wl = 2'b00;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_serial_port dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout(dout), .dout_oe(dout_oe), .conv_start(conv_start),
        .conv_addr(conv_addr), .conv_unipolar(conv_unipolar),
        .conv_busy(conv_busy), .conv_done(conv_done), .conv_result(conv_result)
    );

    function automatic logic [11:0] code_of(input logic [3:0] a, input logic u);
        return {a, 8'h00} ^ (u ? 12'h0A5 : 12'h93C);
    endfunction

    // Stand-in conversion core: busy for busy_len clocks, then a done pulse.
    always @(posedge clk) begin
        conv_done  <= 1'b0;
        last_start <= conv_start;
        if (conv_start) begin
            starts    <= starts + 1;
            if (last_start) wide_starts <= wide_starts + 1;
            got_addr  <= conv_addr;
            got_uni   <= conv_unipolar;
            busy_cnt  <= busy_len;
            conv_busy <= 1'b1;
        end else if (busy_cnt > 0) begin
            busy_cnt <= busy_cnt - 1;
            if (busy_cnt == 1) begin
                conv_busy   <= 1'b0;
                conv_done   <= 1'b1;
                conv_result <= code_of(got_addr, got_uni);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] expect_bits(input logic [11:0] r, input logic m, input logic [1:0] wl);
        logic [15:0] w = {r, 4'h0};
        logic [15:0] v = '0;
        int len = (wl == 2'b01) ? 8 : (wl == 2'b11) ? 16 : 12;
        for (int k = 0; k < 16; k++)
            if (k < len) v[15-k] = m ? w[15-k] : w[16-len+k];
        return v;
    endfunction

    // One frame: nclk serial clocks, command MSB first then junk on din.
    task automatic do_frame(input logic [7:0] cfg, input int nclk,
                            output logic [15:0] got, output int oe_bad);
        got = '0;
        oe_bad = 0;
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < nclk; i++) begin
            @(negedge clk) din = (i < 8) ? cfg[7-i] : ~i[0];
            repeat (HALF) @(negedge clk);
            if (i < 16) got[15-i] = dout;
            if (!dout_oe) oe_bad++;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    // Full frame whose readback is checked against the previous accepted command.
    task automatic frame_check(input string req, input logic [7:0] cfg, input bit accept);
        logic [15:0] got;
        int oe_bad;
        int s0 = starts;
        do_frame(cfg, 16, got, oe_bad);
        check({req, " readback"}, {16'h0, got}, {16'h0, expect_bits(e_res, e_msbf, e_wl)});
        check("R10 oe during frame", oe_bad, 0);
        repeat (busy_len + 40) @(negedge clk);
        check("R3/R5 start count", starts - s0, accept ? 1 : 0);
        if (accept) begin
            check("R2 address decode", {28'h0, got_addr}, {28'h0, cfg[7:4]});
            check("R2 unipolar decode", {31'h0, got_uni}, {31'h0, cfg[3]});
            e_res  = code_of(cfg[7:4], cfg[3]);
            e_msbf = cfg[2];
            e_wl   = cfg[1:0];
        end
    endtask

    task automatic t_reset();
        check("R1 oe after reset", {31'h0, dout_oe}, 0);
        check("R1 start after reset", {31'h0, conv_start}, 0);
        check("R10 dout idle", {31'h0, dout}, 0);
    endtask

    task automatic t_first_frame();   // R1: zeros out, command 1011/uni/MSB/12
        frame_check("R1 first frame", 8'b1011_1_1_00, 1);
    endtask

    task automatic t_msb12();         // R7, R6: previous 12-bit MSB result
        frame_check("R7 msb 12", 8'b0110_0_1_01, 1);
    endtask

    task automatic t_len8();          // R8: 8-bit MSB readback
        frame_check("R8 length 8", 8'b0011_1_0_11, 1);
    endtask

    task automatic t_lsb16();         // R9, R8: 16-bit LSB readback
        frame_check("R9 lsb 16", 8'b1100_0_0_10, 1);
    endtask

    task automatic t_partial();       // R4: aborted frame, then older result still returned
        logic [15:0] got;
        int oe_bad;
        int s0 = starts;
        do_frame(8'b0101_1_1_11, 5, got, oe_bad);
        repeat (busy_len + 40) @(negedge clk);
        check("R4 partial no start", starts - s0, 0);
        frame_check("R4 R9 lsb 12 after partial", 8'b1001_1_0_01, 1);
    endtask

    task automatic t_busy();          // R5: command while busy dropped
        logic [15:0] got;
        int oe_bad;
        int s0;
        busy_len = 600;
        frame_check("R8 lsb 8", 8'b1110_1_1_11, 1);
        // frame_check waited only busy_len+40; core already done, so start a fresh busy
        busy_len = 600;
        s0 = starts;
        do_frame(8'b0111_0_1_00, 16, got, oe_bad);   // accepted, core now busy
        check("R8 msb 16 readback", {16'h0, got}, {16'h0, expect_bits(e_res, e_msbf, e_wl)});
        e_res = code_of(4'b0111, 1'b0); e_msbf = 1'b1; e_wl = 2'b00;
        do_frame(8'b0001_1_0_11, 16, got, oe_bad);   // core still busy: dropped
        check("R5 busy drop", starts - s0, 1);
        repeat (700) @(negedge clk);
        busy_len = 20;
        frame_check("R5 R6 older result kept", 8'b1010_0_1_11, 1);
    endtask

    task automatic t_idle();
        repeat (4) @(negedge clk);
        check("R10 oe between frames", {31'h0, dout_oe}, 0);
        check("R10 dout between frames", {31'h0, dout}, 0);
        check("R3 single-cycle starts", wide_starts, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_first_frame();
        t_msb12();
        t_len8();
        t_lsb16();
        t_partial();
        t_busy();
        t_idle();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule